// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block sits between a single-requester memory port and the command pins of an SDR SDRAM with four internal banks. It turns each read or write request into the shortest legal command sequence. A request carries a write flag and an address split into bank, row and column fields (`{bank, row, col}`, bank in the top two bits). In open-row mode a bank is left active after each access. Whether a request hits an open row, finds the bank empty, or finds a different row open decides whether it gets a bare column command, an activate and then a column command, or a precharge, an activate and then a column command. In auto-precharge mode the column command closes the bank itself. The block then holds off further commands until the bank's recovery time has passed.

The block also runs a refresh timer. When the timer reaches a programmable interval and the sequencer is idle, it precharges all banks, forgets every open row and issues an auto-refresh. The interval is meant to be set no longer than the longest time a row may stay active. The block also drives the data mask pin so that reads get a two-cycle lead.

The command outputs are combinational from the state and the request. `req_ready` is high only in the cycle that puts the column command on the bus. The requester holds `req_write` and `req_addr` stable until it sees `req_ready`.

Top module: `sdram_row_sequencer`

## Requirements
- R1: The command code on `cmd` is 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRE, 5 REF. In the first cycle after reset is released the block issues PRE with `cmd_ap`=1 (all banks), and `req_ready` stays low.
- R2: A request to a bank with no open row issues ACT carrying the row on `cmd_addr`. The column command carrying the zero-extended column follows TRCD cycles later, with NOP in between.
- R3: In open-row mode a write to the row already open in its bank issues WRITE with `cmd_ap`=0 in the first cycle the request is seen, with no ACT.
- R4: A read to the row already open in its bank issues one NOP and then READ on the next cycle, with no ACT.
- R5: A request to a bank that has a different row open issues PRE to that bank with `cmd_ap`=0. ACT follows `cfg_pre_wait`+1 cycles after the PRE (0 to 3 NOPs between), and the column command follows TRCD cycles after the ACT.
- R6: `cmd_ap` on READ and WRITE equals the inverse of `cfg_open_row`. In auto-precharge mode the bank is closed after the access, so the next access to the same row starts with ACT again.
- R7: After WRITE with `cmd_ap`=1 the block issues NOP for TRWL+TAP cycles. After READ with `cmd_ap`=1 it issues NOP for TAP cycles.
- R8: In open-row mode, back-to-back write requests to the same open row get WRITE commands on consecutive cycles.
- R9: When the refresh timer has reached `cfg_ref_interval` and the sequencer is idle, the block issues PRE with `cmd_ap`=1 and then REF `cfg_pre_wait`+1 cycles later, followed by TRFC NOPs. Refresh takes precedence over a waiting request, and all banks count as closed afterwards.
- R10: `dqm_mask` is 0 in every READ cycle and in the NOP cycle just before it, and in every WRITE cycle. It is 1 in all other cycles.
- R11: `req_ready` is high only together with a READ or WRITE command for a valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_open_row | input | 1 | 1 = leave rows open, 0 = auto-precharge every access |
| cfg_pre_wait | input | 2 | Extra NOP cycles between PRE and the next ACT or REF |
| cfg_ref_interval | input | REF_W | Refresh interval in cycles |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2+ROW_W+COL_W | Request address `{bank, row, col}` |
| req_ready | output | 1 | Request accepted (column command this cycle) |
| cmd | output | 3 | SDRAM command code (see R1) |
| cmd_bank | output | 2 | Bank address |
| cmd_addr | output | ROW_W | Row for ACT, zero-extended column for READ/WRITE |
| cmd_ap | output | 1 | Auto-precharge on READ/WRITE, all banks on PRE |
| dqm_mask | output | 1 | Data mask, 1 = masked |

## Verification
The sequencer is driven through a fixed walk of the bank table. It covers an empty bank, a repeated row in the same bank, a different row in an occupied bank, the same bank again after a mode switch, and the same bank after a refresh. Each pattern yields a different command trace (column only, NOP then READ, ACT then column, PRE then ACT then column). A wrong hit or miss decision therefore shows up in the index of the ACT or column command. The precharge wait is run at two settings, so a fixed rather than programmed gap is caught. Auto-precharge writes and reads are each followed at once by a new request, so the length of the recovery NOP run is measured for both.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;
    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_REF   = 3'd5
    } cmd_e;

    typedef enum logic [3:0] {
        ST_INIT, ST_INIT_GAP, ST_IDLE, ST_HIT_RD, ST_PRE_GAP,
        ST_ACT_GAP, ST_RECOV, ST_REF_PRE_GAP, ST_REF_GAP
    } state_e;
endpackage

// File: rtl/sdram_bank_table.sv
`timescale 1ns/1ps
module sdram_bank_table #(
    parameter int NBANK = 4,
    parameter int ROW_W = 12,
    localparam int BA_W = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BA_W-1:0]  bank,
    input  logic [ROW_W-1:0] row,
    input  logic             upd_act,
    input  logic             upd_close,
    input  logic             upd_close_all,
    output logic             is_open,
    output logic             is_hit
);
    logic [NBANK-1:0] valid_q;
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic             valid_d;
        logic [ROW_W-1:0] row_d;
        logic             sel;
        always_comb begin
            sel     = (bank == BA_W'(b));
            valid_d = valid_q[b];
            row_d   = row_q[b];
            if (upd_close_all || (sel && upd_close)) valid_d = 1'b0;
            if (sel && upd_act) begin
                valid_d = 1'b1;
                row_d   = row;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[b] <= 1'b0;
                row_q[b]   <= '0;
            end else begin
                valid_q[b] <= valid_d;
                row_q[b]   <= row_d;
            end
        end
    end

    assign is_open = valid_q[bank];
    assign is_hit  = valid_q[bank] && (row_q[bank] == row);
endmodule

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
module sdram_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] interval,
    input  logic             clear,
    output logic             due
);
    logic [REF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)               cnt_d = '0;
        else if (&cnt_q)         cnt_d = cnt_q;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign due = (cnt_q >= interval);
endmodule

// File: rtl/sdram_row_sequencer.sv
`timescale 1ns/1ps
module sdram_row_sequencer
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 8,
    parameter int REF_W = 16,
    parameter int TRCD  = 2,
    parameter int TRWL  = 2,
    parameter int TAP   = 2,
    parameter int TRFC  = 4,
    localparam int BA_W   = 2,
    localparam int ADDR_W = BA_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_open_row,
    input  logic [1:0]        cfg_pre_wait,
    input  logic [REF_W-1:0]  cfg_ref_interval,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [2:0]        cmd,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              cmd_ap,
    output logic              dqm_mask
);
    localparam int MAXC0 = (TRWL + TAP > TRFC) ? TRWL + TAP : TRFC;
    localparam int MAXC1 = (MAXC0 > TRCD) ? MAXC0 : TRCD;
    localparam int MAXC  = (MAXC1 > 4) ? MAXC1 : 4;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        state_e           st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [BA_W-1:0]  req_bank;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    assign {req_bank, req_row, req_col} = req_addr;

    logic bank_open, bank_hit, ref_due;
    logic upd_act, upd_close, upd_close_all, ref_clear;
    logic col_go, act_go;
    cmd_e cmd_c;

    sdram_bank_table #(.NBANK(4), .ROW_W(ROW_W)) i_table (
        .clk(clk), .rst_n(rst_n), .bank(req_bank), .row(req_row),
        .upd_act(upd_act), .upd_close(upd_close), .upd_close_all(upd_close_all),
        .is_open(bank_open), .is_hit(bank_hit)
    );

    sdram_refresh_timer #(.REF_W(REF_W)) i_refresh (
        .clk(clk), .rst_n(rst_n), .interval(cfg_ref_interval),
        .clear(ref_clear), .due(ref_due)
    );

    always_comb begin
        fsm_d         = fsm_q;
        cmd_c         = CMD_NOP;
        cmd_bank      = req_bank;
        cmd_addr      = '0;
        cmd_ap        = 1'b0;
        dqm_mask      = 1'b1;
        req_ready     = 1'b0;
        upd_act       = 1'b0;
        upd_close     = 1'b0;
        upd_close_all = 1'b0;
        ref_clear     = 1'b0;
        col_go        = 1'b0;
        act_go        = 1'b0;

        case (fsm_q.st)
            ST_INIT: begin
                cmd_c         = CMD_PRE;
                cmd_ap        = 1'b1;
                upd_close_all = 1'b1;
                fsm_d.st      = ST_INIT_GAP;
                fsm_d.cnt     = CNT_W'(cfg_pre_wait);
            end
            ST_INIT_GAP, ST_RECOV, ST_REF_GAP: begin
                if (fsm_q.cnt == '0) fsm_d.st = ST_IDLE;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            ST_IDLE: begin
                if (ref_due) begin
                    cmd_c         = CMD_PRE;
                    cmd_ap        = 1'b1;
                    upd_close_all = 1'b1;
                    ref_clear     = 1'b1;
                    fsm_d.st      = ST_REF_PRE_GAP;
                    fsm_d.cnt     = CNT_W'(cfg_pre_wait);
                end else if (req_valid) begin
                    if (bank_hit) begin
                        if (req_write) col_go = 1'b1;
                        else begin
                            dqm_mask = 1'b0;
                            fsm_d.st = ST_HIT_RD;
                        end
                    end else if (bank_open) begin
                        cmd_c     = CMD_PRE;
                        upd_close = 1'b1;
                        fsm_d.st  = ST_PRE_GAP;
                        fsm_d.cnt = CNT_W'(cfg_pre_wait);
                    end else begin
                        act_go = 1'b1;
                    end
                end
            end
            ST_HIT_RD: col_go = 1'b1;
            ST_PRE_GAP: begin
                if (fsm_q.cnt == '0) act_go = 1'b1;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            ST_ACT_GAP: begin
                if (fsm_q.cnt == '0) col_go = 1'b1;
                else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                    if (fsm_q.cnt == CNT_W'(1) && !req_write) dqm_mask = 1'b0;
                end
            end
            ST_REF_PRE_GAP: begin
                if (fsm_q.cnt == '0) begin
                    cmd_c     = CMD_REF;
                    fsm_d.st  = ST_REF_GAP;
                    fsm_d.cnt = CNT_W'(TRFC - 1);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            default: fsm_d.st = ST_INIT;
        endcase

        if (act_go) begin
            cmd_c     = CMD_ACT;
            cmd_addr  = req_row;
            upd_act   = 1'b1;
            fsm_d.st  = ST_ACT_GAP;
            fsm_d.cnt = CNT_W'(TRCD - 1);
        end

        if (col_go) begin
            cmd_c     = req_write ? CMD_WRITE : CMD_READ;
            cmd_addr  = ROW_W'(req_col);
            cmd_ap    = !cfg_open_row;
            dqm_mask  = 1'b0;
            req_ready = 1'b1;
            if (cfg_open_row) begin
                fsm_d.st = ST_IDLE;
            end else begin
                upd_close = 1'b1;
                fsm_d.st  = ST_RECOV;
                fsm_d.cnt = req_write ? CNT_W'(TRWL + TAP - 1) : CNT_W'(TAP - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_INIT;
            fsm_q.cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign cmd = cmd_c;
endmodule

// File: rtl/sdram_row_sequencer_chk.sv
`timescale 1ns/1ps
module sdram_row_sequencer_chk #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_open_row,
    input logic [1:0]       cfg_pre_wait,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       cmd,
    input logic             cmd_ap,
    input logic             dqm_mask
);
    // R11: ready only with a column command for a valid request
    a_r11_ready_with_column: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (req_valid && (cmd == 3'd2 || cmd == 3'd3)));

    // R6: auto-precharge flag on column commands follows the mode
    a_r6_ap_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2 || cmd == 3'd3) |-> (cmd_ap == !cfg_open_row));

    // R7: a closing write is followed by a NOP
    a_r7_write_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd3 && cmd_ap) |=> (cmd == 3'd0));

    // R10: read mask lead of two cycles
    a_r10_read_mask_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2) |-> (!dqm_mask && !$past(dqm_mask) && $past(cmd) == 3'd0));

    // R5: a non-zero precharge wait puts a NOP after PRE
    a_r5_pre_wait_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd4 && cfg_pre_wait != 2'd0) |=> (cmd == 3'd0));
endmodule

bind sdram_row_sequencer sdram_row_sequencer_chk #(.ROW_W(ROW_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_open_row(cfg_open_row),
    .cfg_pre_wait(cfg_pre_wait), .req_valid(req_valid), .req_ready(req_ready),
    .cmd(cmd), .cmd_ap(cmd_ap), .dqm_mask(dqm_mask)
);

// File: tb/test_sdram_row_sequencer.sv
`timescale 1ns/1ps
module test_sdram_row_sequencer;
    localparam int ROW_W = 12;
    localparam int COL_W = 8;
    localparam int REF_W = 16;
    localparam int ADDR_W = 2 + ROW_W + COL_W;
    localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_open_row = 1'b1;
    logic [1:0] cfg_pre_wait = 2'd2;
    logic [REF_W-1:0] cfg_ref_interval = '1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready;
    logic [2:0] cmd;
    logic [1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_addr;
    logic cmd_ap;
    logic dqm_mask;

    sdram_row_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .REF_W(REF_W),
        .TRCD(2), .TRWL(2), .TAP(2), .TRFC(4)) i_sdram_row_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_open_row(cfg_open_row),
        .cfg_pre_wait(cfg_pre_wait), .cfg_ref_interval(cfg_ref_interval),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .cmd(cmd), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .dqm_mask(dqm_mask)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int col_cyc = 0;
    int tr_n = 0;
    int tr_cmd [32];
    int tr_addr [32];
    int tr_ap [32];
    int tr_dqm [32];
    int tr_bank [32];
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample(input int i);
        tr_cmd[i]  = int'(cmd);
        tr_addr[i] = int'(cmd_addr);
        tr_ap[i]   = int'(cmd_ap);
        tr_dqm[i]  = int'(dqm_mask);
        tr_bank[i] = int'(cmd_bank);
    endtask

    // Called at a negedge; returns at a negedge after the accepting cycle.
    task automatic do_req(input bit wr, input int b, input int row, input int col);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {b[1:0], row[ROW_W-1:0], col[COL_W-1:0]};
        tr_n = 0;
        for (int i = 0; i < 32; i++) begin
            #1;
            sample(i);
            tr_n = i + 1;
            if (req_ready) begin
                col_cyc = cyc;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle_trace(input int k);
        req_valid = 1'b0;
        for (int i = 0; i < k; i++) begin
            #1;
            sample(i);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 first cmd PRE", int'(cmd), PRE);
        check("R1 first PRE all-bank", int'(cmd_ap), 1);
        check("R1 ready low", int'(req_ready), 0);
        @(negedge clk);
        idle_trace(6);
        check("R10 mask idle", tr_dqm[5], 1);
    endtask

    task automatic t_empty_write;
        do_req(1'b1, 0, 5, 3);
        check("R2 empty length", tr_n, 3);
        check("R2 ACT", tr_cmd[0], ACT);
        check("R2 ACT row", tr_addr[0], 5);
        check("R2 ACT bank", tr_bank[0], 0);
        check("R2 gap NOP", tr_cmd[1], NOP);
        check("R11 column WRITE with ready", tr_cmd[2], WR);
        check("R2 column addr", tr_addr[2], 3);
        check("R10 write mask", tr_dqm[2], 0);
    endtask

    task automatic t_hit_write_b2b;
        int c1;
        do_req(1'b1, 0, 5, 4);
        c1 = col_cyc;
        check("R3 hit write length", tr_n, 1);
        check("R3 hit WRITE", tr_cmd[0], WR);
        check("R3 hit ap", tr_ap[0], 0);
        do_req(1'b1, 0, 5, 6);
        check("R8 second hit WRITE", tr_cmd[0], WR);
        check("R8 consecutive cycles", col_cyc - c1, 1);
    endtask

    task automatic t_hit_read;
        do_req(1'b0, 0, 5, 7);
        check("R4 hit read length", tr_n, 2);
        check("R4 NOP first", tr_cmd[0], NOP);
        check("R4 READ", tr_cmd[1], RD);
        check("R10 lead mask", tr_dqm[0], 0);
        check("R10 read mask", tr_dqm[1], 0);
    endtask

    task automatic t_miss_read;
        do_req(1'b0, 0, 9, 1);
        check("R5 miss length", tr_n, 6);
        check("R5 PRE", tr_cmd[0], PRE);
        check("R5 PRE single bank", tr_ap[0], 0);
        check("R5 wait NOP", tr_cmd[2], NOP);
        check("R5 ACT after wait", tr_cmd[3], ACT);
        check("R5 ACT row", tr_addr[3], 9);
        check("R10 mask before READ", tr_dqm[4], 0);
        check("R10 mask in gap", tr_dqm[1], 1);
        check("R5 READ", tr_cmd[5], RD);
        cfg_pre_wait = 2'd0;
        do_req(1'b1, 0, 1, 0);
        check("R5 zero-wait length", tr_n, 4);
        check("R5 zero-wait ACT", tr_cmd[1], ACT);
        cfg_pre_wait = 2'd2;
    endtask

    task automatic t_empty_read;
        do_req(1'b0, 2, 3, 9);
        check("R2 empty read length", tr_n, 3);
        check("R2 empty read ACT", tr_cmd[0], ACT);
        check("R10 empty read lead", tr_dqm[1], 0);
        check("R2 empty read col", tr_addr[2], 9);
    endtask

    task automatic t_auto_mode;
        cfg_open_row = 1'b0;
        do_req(1'b1, 1, 7, 2);
        check("R6 auto write ap", tr_ap[2], 1);
        check("R6 auto WRITE", tr_cmd[2], WR);
        do_req(1'b0, 1, 7, 2);
        check("R7 write recovery length", tr_n, 7);
        check("R7 recovery NOP", tr_cmd[3], NOP);
        check("R6 bank closed ACT again", tr_cmd[4], ACT);
        check("R6 auto read ap", tr_ap[6], 1);
        do_req(1'b0, 1, 7, 3);
        check("R7 read recovery length", tr_n, 5);
        check("R7 read recovery ACT", tr_cmd[2], ACT);
        idle_trace(4);
        cfg_open_row = 1'b1;
    endtask

    task automatic t_refresh;
        do_req(1'b1, 3, 4, 0);
        check("R2 bank3 open", tr_cmd[0], ACT);
        cfg_ref_interval = '0;
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = {2'd3, 12'd4, 8'd1};
        #1;
        check("R9 PRE all", int'(cmd), PRE);
        check("R9 PRE all flag", int'(cmd_ap), 1);
        check("R9 refresh beats request", int'(req_ready), 0);
        @(negedge clk);
        cfg_ref_interval = '1;
        req_valid = 1'b0;
        idle_trace(8);
        check("R9 wait NOP", tr_cmd[1], NOP);
        check("R9 REF", tr_cmd[2], REF);
        check("R9 TRFC NOP", tr_cmd[6], NOP);
        do_req(1'b1, 3, 4, 1);
        check("R9 rows closed", tr_cmd[0], ACT);
        check("R9 length", tr_n, 3);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_empty_write;
        t_hit_write_b2b;
        t_hit_read;
        t_miss_read;
        t_empty_read;
        t_auto_mode;
        t_refresh;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule